// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request port and an external asynchronous static RAM with 18 address bits and 8 data bits. A client offers a request with a valid/ready handshake: a write flag, an address and, for writes, a data byte. The controller turns each accepted request into a correctly timed pin sequence on the memory side. It drives a pair of chip selects of opposite polarity, a write strobe, an output enable, the address bus and the output half of a tri-state data bus as a value plus a drive enable. Read data comes back on its own port with a one-cycle valid strobe.

All memory timing is expressed in nanoseconds as parameters. It is converted to clock cycles by ceiling division with a floor of one cycle. The read wait covers the later of the address-to-data and output-enable-to-data times. The write-strobe width covers the pulse, data-setup and address-to-end minimums. A fixed wait after every read keeps the controller's data drivers off while the memory releases the bus. All memory-side pins come straight from flops, so they cannot glitch.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the pins sit idle: mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0 and rd_valid=0, and req_ready=1.
- R2: The two chip selects always move together. The memory counts as selected only when mem_ce_n=0 and mem_ce=1, and it is deselected (mem_ce_n=1, mem_ce=0) whenever req_ready is high.
- R3: A read holds the memory selected with mem_oe_n=0 and mem_we_n=1 and the address unchanged for ACC_CYC cycles. ACC_CYC is the larger of ceil(T_AA_NS/CLK_PERIOD_NS) and ceil(T_DOE_NS/CLK_PERIOD_NS), with a minimum of 1; this is 6 at the defaults with an 8 ns clock. rd_data is taken at the end of the last of those cycles. rd_valid is high for exactly one cycle, ACC_CYC clock edges after the accepting edge.
- R4: A write selects the memory for one cycle with mem_we_n=1 and then holds mem_we_n=0 for exactly WP_CYC cycles. WP_CYC is the largest of the ceiling cycle counts of T_PWE_NS, T_SD_NS and T_AW_NS, which is 5 at the defaults. One further selected cycle with mem_we_n=1 follows. mem_we_n is low only while the memory is selected, and the address and driven data stay constant for the whole low time.
- R5: mem_oe_n stays high for the whole of every write, and mem_dq_oe is never high while mem_oe_n is low.
- R6: After mem_oe_n rises at the end of a read, mem_dq_oe stays low for more than TA_CYC = ceil(T_HZOE_NS/CLK_PERIOD_NS) cycles (3 at the defaults).
- R7: req_ready falls on the cycle after a request is accepted and stays low until the controller is idle again. Successive selections of the memory start at least CYC_CYC = ceil(T_RC_NS/CLK_PERIOD_NS) cycles apart (6 at the defaults).
- R8: A read returns the byte most recently written to that address. This holds when the read directly follows the write and when other addresses are written in between.
- R9: An active-low reset asserted during an access returns the pins at once to the idle state of R1. After reset is released, reads and writes work normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds read result |
| rd_data | output | 8 | Read result |
| mem_ce_n | output | 1 | Active-low chip select to the memory |
| mem_ce | output | 1 | Active-high chip select to the memory |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_o | output | 8 | Data value for the bus pads |
| mem_dq_oe | output | 1 | Drive enable for the bus pads |
| mem_dq_i | input | 8 | Data seen on the bus pads |

## Verification
The bench's memory model returns the inverted byte until a read has been active for the full access count. A controller that samples one cycle early therefore returns corrupted data instead of quietly passing. The model also counts write strobes that are too short, and address or data that move during a strobe. It counts controller drive while the memory may still be driving, output enable low during a write, and selections that start closer together than the cycle time. Each of these failures shows up as a non-zero counter. The tests cover a read directly after a write to the same address, a write directly after a read, and both ends of the address range. A reset is also dropped into the middle of a write pulse; a design that kept the strobe low or left the bus driven there would be caught at the pins.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    IDLE       = 3'd0,
    RD_ACCESS  = 3'd1,
    RD_DONE    = 3'd2,
    WR_SETUP   = 3'd3,
    WR_PULSE   = 3'd4,
    WR_RECOVER = 3'd5,
    TURNAROUND = 3'd6
  } ctl_state_t;

  // Memory-side pin set, registered as one word.
  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_set_t;

  // Nanosecond minimum to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int bits_for(input int v);
    int b;
    b = 1;
    while ((1 << b) <= v) b++;
    return b;
  endfunction

  // Pin levels wanted while the machine is in a given state.
  function automatic pin_set_t pins_for(input ctl_state_t s);
    pin_set_t p;
    p = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (s)
      RD_ACCESS:  p = '{sel_n: 1'b0, sel: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      WR_SETUP:   p = '{sel_n: 1'b0, sel: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      WR_PULSE:   p = '{sel_n: 1'b0, sel: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      WR_RECOVER: p = '{sel_n: 1'b0, sel: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      default:    p = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ACC_CYC = 6,
  parameter int WP_CYC  = 5,
  parameter int TA_CYC  = 3,
  parameter int CYC_CYC = 6,
  parameter int TW      = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  output logic     req_ready,
  output logic     accept,
  output logic     capture,
  output pin_set_t pins_q
);
  localparam int CW = TW + 1;

  ctl_state_t    state_q, state_d;
  logic          ph_load, ph_zero, cy_zero;
  logic [TW-1:0] ph_val;

  sram_ctl_timer #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  sram_ctl_timer #(.W(TW)) u_cycle (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val(TW'(CYC_CYC - 1)), .zero(cy_zero)
  );

  assign req_ready = (state_q == IDLE) && cy_zero;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = '0;
    capture = 1'b0;
    case (state_q)
      IDLE: if (accept) begin
        if (req_write) state_d = WR_SETUP;
        else begin
          state_d = RD_ACCESS;
          ph_load = 1'b1;
          ph_val  = TW'(ACC_CYC - 1);
        end
      end
      RD_ACCESS: if (ph_zero) begin
        capture = 1'b1;
        state_d = RD_DONE;
      end
      RD_DONE: begin
        state_d = TURNAROUND;
        ph_load = 1'b1;
        ph_val  = TW'(TA_CYC - 1);
      end
      TURNAROUND: if (ph_zero) state_d = IDLE;
      WR_SETUP: begin
        state_d = WR_PULSE;
        ph_load = 1'b1;
        ph_val  = TW'(WP_CYC - 1);
      end
      WR_PULSE:   if (ph_zero) state_d = WR_RECOVER;
      WR_RECOVER: state_d = IDLE;
      default:    state_d = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IDLE;
      pins_q  <= pins_for(IDLE);
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
    end
  end

  // Observation counters for the timing properties below.
  logic [CW-1:0] we_low_cnt, oe_high_cnt, sel_gap_cnt;
  logic          sel_prev_q;
  logic          sel_start;
  assign sel_start = pins_q.sel && !sel_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= '1;
      sel_gap_cnt <= '1;
      sel_prev_q  <= 1'b0;
    end else begin
      sel_prev_q <= pins_q.sel;
      if (pins_q.we_n) we_low_cnt <= '0;
      else if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
      if (!pins_q.oe_n) oe_high_cnt <= '0;
      else if (oe_high_cnt != '1) oe_high_cnt <= oe_high_cnt + 1'b1;
      if (sel_start) sel_gap_cnt <= CW'(1);
      else if (sel_gap_cnt != '1) sel_gap_cnt <= sel_gap_cnt + 1'b1;
    end
  end

  AST_ENABLES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.sel_n != pins_q.sel); // R2
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> pins_q.sel_n); // R2
  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.we_n |-> (!pins_q.sel_n && pins_q.sel)); // R4
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.we_n) |-> (int'(we_low_cnt) >= WP_CYC)); // R4
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.we_n |-> pins_q.oe_n); // R5
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    pins_q.dq_oe |-> pins_q.oe_n); // R5
  AST_OE_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_q.dq_oe) |-> (int'(oe_high_cnt) > TA_CYC)); // R6
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7
  AST_SEL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |-> (int'(sel_gap_cnt) >= CYC_CYC)); // R7
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 45,
  parameter int T_AA_NS       = 45,
  parameter int T_DOE_NS      = 22,
  parameter int T_PWE_NS      = 35,
  parameter int T_SD_NS       = 25,
  parameter int T_AW_NS       = 35,
  parameter int T_HZOE_NS     = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int ACC_CYC = max3(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS), 1);
  localparam int WP_CYC  = max3(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                ns_to_cycles(T_SD_NS, CLK_PERIOD_NS),
                                ns_to_cycles(T_AW_NS, CLK_PERIOD_NS));
  localparam int TA_CYC  = ns_to_cycles(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int CYC_CYC = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = max3(max3(ACC_CYC, WP_CYC, TA_CYC), CYC_CYC, 1);
  localparam int TW      = bits_for(MAX_CYC);

  logic     accept, capture;
  pin_set_t pins;

  sram_ctl_fsm #(
    .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC),
    .CYC_CYC(CYC_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .capture(capture), .pins_q(pins)
  );

  sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .dq_in(mem_dq_i),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Address and write data are held from acceptance to the next request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  assign mem_ce_n  = pins.sel_n;
  assign mem_ce    = pins.sel;
  assign mem_we_n  = pins.we_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_dq_oe = pins.dq_oe;

  AST_WR_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe)); // R4
  AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R3
endmodule

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [17:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  dq_i = 8'h00;

  always #4 clk = ~clk;  // 125 MHz

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(dq_i)
  );

  // Expected cycle counts, restated from the requirements for an 8 ns clock.
  function automatic int cyc8(input int ns);
    int c;
    c = 0;
    while (c * 8 < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction
  localparam int ACC_E = (cyc8(45) > cyc8(22)) ? cyc8(45) : cyc8(22);
  localparam int WP_E  = cyc8(35);
  localparam int TA_E  = cyc8(18);
  localparam int CYC_E = cyc8(45);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing monitors ----------------
  logic [7:0] mem [int];
  int  rd_cyc = 0, hold = 0, wp_cnt = 0, last_wp = 0, since_sel = 100;
  bit  prev_rd = 0, prev_wr = 0, prev_sel = 0;
  logic [17:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;
  int  v_pair = 0, v_rd = 0, v_wr = 0, v_oe = 0, v_ta = 0, v_cyc = 0;

  function automatic logic [7:0] peek(input logic [17:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    bit sel, rd_act, wr_act;
    if (!rst_n) begin
      rd_cyc = 0; hold = 0; wp_cnt = 0; since_sel = 100;
      prev_rd = 0; prev_wr = 0; prev_sel = 0;
    end else begin
      sel    = !mem_ce_n && mem_ce;
      rd_act = sel && !mem_oe_n && mem_we_n;
      wr_act = sel && !mem_we_n;
      if (mem_ce_n == mem_ce) v_pair++;
      if (rd_act && prev_rd && mem_addr != prev_addr) v_rd++;
      if (mem_dq_oe && !mem_oe_n) v_oe++;
      if (mem_dq_oe && hold > 0) v_ta++;
      if (wr_act) begin
        if (!mem_oe_n) v_oe++;
        if (!mem_dq_oe) v_wr++;
        if (prev_wr && (mem_addr != prev_addr || mem_dq_o != prev_dq)) v_wr++;
        wp_cnt++;
      end else if (prev_wr) begin
        if (wp_cnt < WP_E) v_wr++;
        last_wp = wp_cnt;
        mem[int'(prev_addr)] = prev_dq;
        wp_cnt = 0;
      end
      since_sel++;
      if (sel && !prev_sel) begin
        if (since_sel < CYC_E) v_cyc++;
        since_sel = 0;
      end
      if (rd_act) hold = TA_E; else if (hold > 0) hold--;
      rd_cyc   = rd_act ? rd_cyc + 1 : 0;
      prev_rd  = rd_act;
      prev_wr  = wr_act;
      prev_sel = sel;
      prev_addr = mem_addr;
      prev_dq   = mem_dq_o;
    end
  end

  // Data is only correct once the access has lasted ACC_E cycles; before that
  // the model returns the inverted byte.
  always @(negedge clk) begin
    if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
      dq_i = (rd_cyc >= ACC_E - 1) ? peek(mem_addr) : ~peek(mem_addr);
    else
      dq_i = 8'hZZ === 8'hZZ ? 8'h00 : 8'h00;
  end

  // ---------------- request driver ----------------
  task automatic issue(input logic w, input logic [17:0] a, input logic [7:0] d,
                       output logic [7:0] got, output int lat, output logic dropped);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    dropped = !req_ready;
    lat = 0;
    got = 8'h00;
    if (!w) begin
      while (!rd_valid && lat < 50) begin
        @(negedge clk);
        lat++;
      end
      got = rd_data;
    end
  endtask

  // {write, address, data-or-expected}
  localparam logic [26:0] VECS [11] = '{
    {1'b1, 18'h00000, 8'h5A},
    {1'b1, 18'h3FFFF, 8'hC3},
    {1'b0, 18'h00000, 8'h5A},
    {1'b0, 18'h3FFFF, 8'hC3},
    {1'b1, 18'h00000, 8'h11},
    {1'b0, 18'h00000, 8'h11},
    {1'b1, 18'h12345, 8'h7E},
    {1'b1, 18'h12346, 8'h81},
    {1'b0, 18'h12345, 8'h7E},
    {1'b0, 18'h12346, 8'h81},
    {1'b0, 18'h3FFFF, 8'hC3}
  };

  initial begin
    logic [7:0] got;
    int lat;
    logic dropped;
    repeat (3) @(negedge clk);
    // R1: reset state while reset held
    check("R1 ce_n", mem_ce_n, 1);
    check("R1 ce", mem_ce, 0);
    check("R1 we_n", mem_we_n, 1);
    check("R1 oe_n", mem_oe_n, 1);
    check("R1 dq_oe", mem_dq_oe, 0);
    check("R1 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R2 deselected when idle", {mem_ce_n, mem_ce}, 2'b10);

    for (int i = 0; i < 11; i++) begin
      issue(VECS[i][26], VECS[i][25:8], VECS[i][7:0], got, lat, dropped);
      check("R7 ready low after accept", dropped, 1);
      if (!VECS[i][26]) begin
        check("R8 read data", got, VECS[i][7:0]);
        check("R3 read latency", lat, ACC_E);
        @(negedge clk);
        check("R3 rd_valid one cycle", rd_valid, 0);
      end
    end
    repeat (12) @(negedge clk);
    check("R2 enables paired", v_pair, 0);
    check("R2 idle deselected", {mem_ce_n, mem_ce}, 2'b10);
    check("R3 address stable in read", v_rd, 0);
    check("R4 write stability", v_wr, 0);
    check("R4 strobe width", last_wp, WP_E);
    check("R5 oe/drive conflict", v_oe, 0);
    check("R6 turnaround", v_ta, 0);
    check("R7 cycle spacing", v_cyc, 0);

    // R9: reset dropped into a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00ABC; req_wdata = 8'h99;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R4 strobe low in pulse", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    check("R9 we_n on reset", mem_we_n, 1);
    check("R9 select on reset", {mem_ce_n, mem_ce}, 2'b10);
    check("R9 drive off on reset", mem_dq_oe, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", req_ready, 1);
    issue(1'b1, 18'h00ABC, 8'h3C, got, lat, dropped);
    issue(1'b0, 18'h00ABC, 8'h00, got, lat, dropped);
    check("R9 read after reset", got, 8'h3C);
    issue(1'b0, 18'h12346, 8'h00, got, lat, dropped);
    check("R8 untouched address", got, 8'h81);
    repeat (10) @(negedge clk);
    check("R4 write stability after reset", v_wr, 0);
    check("R6 turnaround after reset", v_ta, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule